// File: doc/BRIEF.md
# Banked Memory Attribute Indirection Unit

This block stores the attribute bytes used by a stage-one address translation. Two 32-bit registers each carry four 8-bit attribute slots. A translation entry refers to one of the eight slots through a 3-bit index. Each register has two copies, one for the secure world and one for the non-secure world. The security state that comes with a lookup or a register access picks the copy.

A lookup returns the selected byte. It also returns a decoded view of that byte: a memory type (strongly-ordered, device or normal), outer and inner cacheability, read and write allocate hints for each level, and a flag for encodings that have no defined meaning. A write-protect input freezes both secure copies. Non-secure copies stay writable at all times. Register reads and lookups are combinational from the stored state. A write takes effect at the clock edge.

Top module: `mattr_unit`

## Requirements
- R1: After reset, all four register copies read as zero. A lookup of any slot returns attribute 0x00 and memory type strongly-ordered.
- R2: Lookup index bit 2 selects the register: 0 selects register 0 and 1 selects register 1. Index bits [1:0] select the byte lane, so lane k is bits [8k+7:8k] of that register.
- R3: When the security input is 1, lookups and register accesses use the secure copy. When it is 0, they use the non-secure copy. A write to one copy leaves the other copy unchanged.
- R4: While `sec_wr_lock_i` is 1, secure writes do not change either secure copy. Non-secure writes still take effect.
- R5: `reg_rdata_o` returns all 32 bits of the register that `reg_sel_i` addresses (0 addresses register 0, 1 addresses register 1), in the copy that `reg_secure_i` picks.
- R6: Memory type encoding is 0 = strongly-ordered, 1 = device, 2 = normal. With attribute bits [7:4] = 0000, a low nibble of 0000 gives strongly-ordered, 0100 gives device, and any other low nibble is unpredictable.
- R7: Cacheability encoding is 0 = non-cacheable, 1 = write-through, 2 = write-back. With a nonzero high nibble, the outer level decodes from bits [7:4] as follows: 0100 gives non-cacheable, 00xx gives write-through, 01xx (xx not 00) gives write-back, 10xx gives write-through, 11xx gives write-back.
- R8: With a nonzero high nibble, the inner level decodes bits [3:0] using the same table as R7. A low nibble of 0000 is unpredictable.
- R9: For a cacheable level, the read-allocate hint is nibble bit 1 and the write-allocate hint is nibble bit 0, with 1 meaning allocate. Hints are 0 for a non-cacheable level and for non-normal memory.
- R10: `lk_unpred_o` is 1 for exactly the unpredictable encodings of R6 and R8. When it is 1, the memory type is strongly-ordered, both cacheabilities are non-cacheable and all hints are 0.
- R11: A lookup in the same cycle as a write to the selected copy returns the old byte. The new byte is returned from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select for write and read |
| reg_secure_i | input | 1 | Security state of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the addressed copy |
| sec_wr_lock_i | input | 1 | Blocks writes to the secure copies |
| lk_idx_i | input | 3 | Attribute slot index |
| lk_secure_i | input | 1 | Security state of the lookup |
| lk_attr_o | output | 8 | Selected attribute byte |
| lk_mem_type_o | output | 2 | Memory type |
| lk_outer_pol_o | output | 2 | Outer cacheability |
| lk_inner_pol_o | output | 2 | Inner cacheability |
| lk_outer_ra_o | output | 1 | Outer read-allocate hint |
| lk_outer_wa_o | output | 1 | Outer write-allocate hint |
| lk_inner_ra_o | output | 1 | Inner read-allocate hint |
| lk_inner_wa_o | output | 1 | Inner write-allocate hint |
| lk_unpred_o | output | 1 | Unpredictable encoding |

## Verification
The decoder is swept across all 256 byte values, written through the register port and looked up on the following cycle. This separates the device and strongly-ordered codes from the reserved low nibbles, the transient-style 00xx/01xx outer codes from the plain ones, and the zero inner nibble from valid ones. Each sweep write is paired with a same-cycle lookup, which tells apart old-value and write-through behaviour. Directed lock sequences and a long random mix of secure and non-secure writes, reads and lookups across all indices expose wrong banking, a wrong lane or register select, and lock leaks. A behavioural model checks every output on every cycle.

// File: rtl/mattr_pkg.sv
package mattr_pkg;

    typedef enum logic [1:0] {
        MT_STRONG = 2'd0,
        MT_DEVICE = 2'd1,
        MT_NORMAL = 2'd2
    } mem_type_e;

    typedef enum logic [1:0] {
        CA_NONE = 2'd0,
        CA_WT   = 2'd1,
        CA_WB   = 2'd2
    } cache_pol_e;

    typedef struct packed {
        cache_pol_e pol;
        logic       ra;
        logic       wa;
        logic       bad;
    } nib_dec_t;

endpackage

// File: rtl/mattr_bank.sv
module mattr_bank #(
    parameter int REG_W    = 32,
    parameter int ATTR_W   = 8,
    parameter int NUM_REGS = 2,
    localparam int SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int LANES   = REG_W / ATTR_W,
    localparam int LANE_W  = $clog2(LANES),
    localparam int IDX_W   = SEL_W + LANE_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic              wr_secure_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic              sec_lock_i,
    input  logic [SEL_W-1:0]  rd_sel_i,
    input  logic              rd_secure_i,
    output logic [REG_W-1:0]  rd_data_o,
    input  logic [IDX_W-1:0]  lk_idx_i,
    input  logic              lk_secure_i,
    output logic [ATTR_W-1:0] lk_attr_o
);

    typedef struct packed {
        logic [NUM_REGS-1:0][REG_W-1:0] sec;
        logic [NUM_REGS-1:0][REG_W-1:0] ns;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            if (wr_secure_i) begin
                if (!sec_lock_i) begin
                    st_d.sec[wr_sel_i] = wr_data_i;
                end
            end else begin
                st_d.ns[wr_sel_i] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = rd_secure_i ? st_q.sec[rd_sel_i] : st_q.ns[rd_sel_i];

    logic [SEL_W-1:0]  lk_reg;
    logic [LANE_W-1:0] lk_lane;
    logic [REG_W-1:0]  lk_word;

    assign lk_reg    = lk_idx_i[IDX_W-1:LANE_W];
    assign lk_lane   = lk_idx_i[LANE_W-1:0];
    assign lk_word   = lk_secure_i ? st_q.sec[lk_reg] : st_q.ns[lk_reg];
    assign lk_attr_o = lk_word[lk_lane*ATTR_W +: ATTR_W];

    // R4: a locked secure write leaves both secure copies untouched
    a_r4_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_secure_i && sec_lock_i) |=> (st_q.sec == $past(st_q.sec)));

    // R3: a non-secure write never disturbs the secure copies
    a_r3_ns_spares_secure: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_secure_i) |=> (st_q.sec == $past(st_q.sec)));

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_chk
        // R4: non-secure writes land even while the lock is held
        a_r4_ns_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_en_i && !wr_secure_i && (wr_sel_i == SEL_W'(k)))
            |=> (st_q.ns[k] == $past(wr_data_i)));
    end

endmodule

// File: rtl/mattr_nibble_dec.sv
module mattr_nibble_dec
    import mattr_pkg::*;
(
    input  logic [3:0] nib_i,
    output nib_dec_t   dec_o
);

    always_comb begin
        dec_o.pol = CA_NONE;
        dec_o.ra  = 1'b0;
        dec_o.wa  = 1'b0;
        dec_o.bad = 1'b0;
        unique case (nib_i[3:2])
            2'b00: begin
                if (nib_i[1:0] == 2'b00) begin
                    dec_o.bad = 1'b1;
                end else begin
                    dec_o.pol = CA_WT;
                    dec_o.ra  = nib_i[1];
                    dec_o.wa  = nib_i[0];
                end
            end
            2'b01: begin
                if (nib_i[1:0] != 2'b00) begin
                    dec_o.pol = CA_WB;
                    dec_o.ra  = nib_i[1];
                    dec_o.wa  = nib_i[0];
                end
            end
            2'b10: begin
                dec_o.pol = CA_WT;
                dec_o.ra  = nib_i[1];
                dec_o.wa  = nib_i[0];
            end
            default: begin
                dec_o.pol = CA_WB;
                dec_o.ra  = nib_i[1];
                dec_o.wa  = nib_i[0];
            end
        endcase
    end

endmodule

// File: rtl/mattr_attr_decode.sv
module mattr_attr_decode
    import mattr_pkg::*;
(
    input  logic [7:0] attr_i,
    output mem_type_e  mem_type_o,
    output cache_pol_e outer_pol_o,
    output cache_pol_e inner_pol_o,
    output logic       outer_ra_o,
    output logic       outer_wa_o,
    output logic       inner_ra_o,
    output logic       inner_wa_o,
    output logic       unpred_o
);

    localparam int LEVELS = 2;   // 0 = inner nibble, 1 = outer nibble

    nib_dec_t lvl [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        mattr_nibble_dec u_nib (
            .nib_i (attr_i[g*4 +: 4]),
            .dec_o (lvl[g])
        );
    end

    logic [3:0] hi, lo;
    assign hi = attr_i[7:4];
    assign lo = attr_i[3:0];

    always_comb begin
        mem_type_o  = MT_STRONG;
        outer_pol_o = CA_NONE;
        inner_pol_o = CA_NONE;
        outer_ra_o  = 1'b0;
        outer_wa_o  = 1'b0;
        inner_ra_o  = 1'b0;
        inner_wa_o  = 1'b0;
        unpred_o    = 1'b0;
        if (hi == 4'b0000) begin
            if (lo == 4'b0100) begin
                mem_type_o = MT_DEVICE;
            end else if (lo != 4'b0000) begin
                unpred_o = 1'b1;
            end
        end else if (lvl[0].bad) begin
            unpred_o = 1'b1;
        end else begin
            mem_type_o  = MT_NORMAL;
            outer_pol_o = lvl[1].pol;
            outer_ra_o  = lvl[1].ra;
            outer_wa_o  = lvl[1].wa;
            inner_pol_o = lvl[0].pol;
            inner_ra_o  = lvl[0].ra;
            inner_wa_o  = lvl[0].wa;
        end
    end

endmodule

// File: rtl/mattr_unit.sv
module mattr_unit
    import mattr_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int NUM_REGS = 2,
    localparam int ATTR_W  = 8,
    localparam int SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int IDX_W   = SEL_W + $clog2(REG_W / ATTR_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic [SEL_W-1:0]  reg_sel_i,
    input  logic              reg_secure_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    input  logic              sec_wr_lock_i,
    input  logic [IDX_W-1:0]  lk_idx_i,
    input  logic              lk_secure_i,
    output logic [ATTR_W-1:0] lk_attr_o,
    output logic [1:0]        lk_mem_type_o,
    output logic [1:0]        lk_outer_pol_o,
    output logic [1:0]        lk_inner_pol_o,
    output logic              lk_outer_ra_o,
    output logic              lk_outer_wa_o,
    output logic              lk_inner_ra_o,
    output logic              lk_inner_wa_o,
    output logic              lk_unpred_o
);

    mem_type_e  mem_type;
    cache_pol_e outer_pol, inner_pol;

    mattr_bank #(
        .REG_W    (REG_W),
        .ATTR_W   (ATTR_W),
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (reg_wr_i),
        .wr_sel_i    (reg_sel_i),
        .wr_secure_i (reg_secure_i),
        .wr_data_i   (reg_wdata_i),
        .sec_lock_i  (sec_wr_lock_i),
        .rd_sel_i    (reg_sel_i),
        .rd_secure_i (reg_secure_i),
        .rd_data_o   (reg_rdata_o),
        .lk_idx_i    (lk_idx_i),
        .lk_secure_i (lk_secure_i),
        .lk_attr_o   (lk_attr_o)
    );

    mattr_attr_decode u_dec (
        .attr_i      (lk_attr_o),
        .mem_type_o  (mem_type),
        .outer_pol_o (outer_pol),
        .inner_pol_o (inner_pol),
        .outer_ra_o  (lk_outer_ra_o),
        .outer_wa_o  (lk_outer_wa_o),
        .inner_ra_o  (lk_inner_ra_o),
        .inner_wa_o  (lk_inner_wa_o),
        .unpred_o    (lk_unpred_o)
    );

    assign lk_mem_type_o  = mem_type;
    assign lk_outer_pol_o = outer_pol;
    assign lk_inner_pol_o = inner_pol;

    // R10: reserved codes collapse to strongly-ordered, uncached, no hints
    a_r10_unpred_forces_strong: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_unpred_o |-> (lk_mem_type_o == 2'd0 && lk_outer_pol_o == 2'd0 &&
                         lk_inner_pol_o == 2'd0 && !lk_outer_ra_o && !lk_outer_wa_o &&
                         !lk_inner_ra_o && !lk_inner_wa_o));

    // R6: the device code decodes to device memory
    a_r6_device_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lk_attr_o == 8'h04) |-> (lk_mem_type_o == 2'd1 && !lk_unpred_o));

    // R8: zero inner nibble under a nonzero outer nibble is reserved
    a_r8_zero_inner_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lk_attr_o[7:4] != 4'h0 && lk_attr_o[3:0] == 4'h0) |-> lk_unpred_o);

    // R9: no allocate hint on a non-cacheable outer level
    a_r9_no_hint_uncached: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lk_outer_pol_o == 2'd0) |-> (!lk_outer_ra_o && !lk_outer_wa_o));

endmodule

// File: tb/mattr_unit_tb_top.sv
module mattr_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_secure = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lock = 1'b0;
    logic [2:0]  lk_idx = '0;
    logic        lk_secure = 1'b0;
    logic [7:0]  lk_attr;
    logic [1:0]  lk_type, lk_opol, lk_ipol;
    logic        lk_ora, lk_owa, lk_ira, lk_iwa, lk_unp;

    always #4 clk = ~clk;   // 125 MHz

    mattr_unit dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .reg_wr_i       (reg_wr),
        .reg_sel_i      (reg_sel),
        .reg_secure_i   (reg_secure),
        .reg_wdata_i    (reg_wdata),
        .reg_rdata_o    (reg_rdata),
        .sec_wr_lock_i  (lock),
        .lk_idx_i       (lk_idx),
        .lk_secure_i    (lk_secure),
        .lk_attr_o      (lk_attr),
        .lk_mem_type_o  (lk_type),
        .lk_outer_pol_o (lk_opol),
        .lk_inner_pol_o (lk_ipol),
        .lk_outer_ra_o  (lk_ora),
        .lk_outer_wa_o  (lk_owa),
        .lk_inner_ra_o  (lk_ira),
        .lk_inner_wa_o  (lk_iwa),
        .lk_unpred_o    (lk_unp)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_sec [2];
    logic [31:0] m_ns  [2];

    task automatic cmp(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int pol_of(input int v);
        if (v < 4)       return 1;
        else if (v == 4) return 0;
        else if (v < 8)  return 2;
        else if (v < 12) return 1;
        else             return 2;
    endfunction

    task automatic check_all(input string tag);
        logic [31:0] word;
        logic [7:0]  b;
        int hi, lo, ty, op, ip, ora, owa, ira, iwa, unp;
        word = reg_secure ? m_sec[reg_sel] : m_ns[reg_sel];
        cmp(tag, "rdata", reg_rdata, word);
        word = lk_secure ? m_sec[lk_idx >> 2] : m_ns[lk_idx >> 2];
        b = 8'((word >> (8 * (lk_idx % 4))) & 32'hFF);
        cmp(tag, "attr", {24'h0, lk_attr}, {24'h0, b});
        hi = int'(b) / 16;
        lo = int'(b) % 16;
        ty = 0; op = 0; ip = 0; ora = 0; owa = 0; ira = 0; iwa = 0; unp = 0;
        if (hi == 0) begin
            if (lo == 4)      ty = 1;
            else if (lo != 0) unp = 1;
        end else if (lo == 0) begin
            unp = 1;
        end else begin
            ty = 2;
            op = pol_of(hi);
            ip = pol_of(lo);
            if (op != 0) begin ora = (hi / 2) % 2; owa = hi % 2; end
            if (ip != 0) begin ira = (lo / 2) % 2; iwa = lo % 2; end
        end
        cmp(unp != 0 ? "R10" : (hi == 0 ? "R6" : "R7"), "type", 32'(lk_type), 32'(ty));
        cmp("R7", "outer_pol", 32'(lk_opol), 32'(op));
        cmp("R8", "inner_pol", 32'(lk_ipol), 32'(ip));
        cmp("R9", "hints", {28'h0, lk_ora, lk_owa, lk_ira, lk_iwa},
            32'(ora * 8 + owa * 4 + ira * 2 + iwa));
        cmp("R10", "unpred", 32'(lk_unp), 32'(unp));
    endtask

    task automatic step(input bit wr, input bit sel, input bit sec, input logic [31:0] d,
                        input bit lk, input bit rsel, input bit rsec,
                        input logic [2:0] idx, input bit lsec, input string tag);
        @(negedge clk);
        reg_wr = wr; reg_wdata = d; lock = lk; lk_idx = idx; lk_secure = lsec;
        reg_sel = wr ? sel : rsel;
        reg_secure = wr ? sec : rsec;
        #1;
        check_all(tag);
        @(posedge clk);
        if (wr) begin
            if (sec) begin
                if (!lk) m_sec[sel] = d;
            end else begin
                m_ns[sel] = d;
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin m_sec[i] = '0; m_ns[i] = '0; end
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state in every copy and slot
        for (int i = 0; i < 8; i++)
            step(0, 0, 0, 0, 0, i[0], i[1], 3'(i), i[2], "R1");

        // R2 / R5: distinct lane values, both registers, non-secure
        step(1, 0, 0, 32'h44FF_AA04, 0, 0, 0, 0, 0, "R5");
        step(1, 1, 0, 32'h0400_BB11, 0, 0, 0, 0, 0, "R5");
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, i[2], 0, 3'(i), 0, "R2");
        // R3: secure copy still zero, then its own contents
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, i[2], 1, 3'(i), 1, "R3");
        step(1, 1, 1, 32'hEE77_0C21, 0, 0, 0, 0, 0, "R3");
        for (int i = 4; i < 8; i++) step(0, 0, 0, 0, 0, 1, 1, 3'(i), 1, "R3");
        for (int i = 4; i < 8; i++) step(0, 0, 0, 0, 0, 1, 0, 3'(i), 0, "R3");

        // Decoder sweep; same-cycle lookup sees the old byte (R11)
        for (int b = 0; b < 256; b++) begin
            step(1, 0, 1, {4{8'(b)}}, 0, 0, 0, 3'(b % 4), 1, "R11");
            step(0, 0, 0, 0, 0, 0, 1, 3'(b % 4), 1, "R2");
        end

        // R4: lock blocks secure writes, not non-secure ones
        step(1, 1, 1, 32'hDEAD_BEEF, 1, 0, 0, 3'd5, 1, "R4");
        step(0, 0, 0, 0, 1, 1, 1, 3'd5, 1, "R4");
        step(1, 1, 0, 32'hCAFE_F00D, 1, 0, 0, 3'd6, 0, "R4");
        step(0, 0, 0, 0, 1, 1, 0, 3'd6, 0, "R4");
        step(1, 0, 1, 32'h1234_5678, 0, 0, 0, 0, 1, "R4");
        step(0, 0, 0, 0, 0, 0, 1, 3'd1, 1, "R4");

        // R3: random mix of accesses in both worlds
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], r[1], r[2], $urandom, r[3] & r[4], r[5], r[6], r[9:7], r[10], "R3");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule